// File: doc/BRIEF.md
# Programmable Interrupt Pin Aggregator

This block merges a bank of interrupt request flags into one interrupt pin for a host processor. Each source has a flag. Most sources raise their flag with a one-cycle event pulse. A few sources are status levels, and for those the flag rises only when the level goes from low to high. The processor drops a flag by writing a 1 into that flag's bit position. Each flag has its own enable bit. A global pin enable decides whether the pin is driven at all.

The pin runs in one of two styles. In level style it pulls low, open-drain fashion, for as long as any enabled flag is pending. In pulse style it drives fixed-width pulses of a selectable polarity. A pulse starts when an enabled request first appears. A new pulse also starts each time the processor drops one enabled flag while another enabled flag is still pending. The pulse width is 20 µs, counted in clocks of the given frequency.

A bus-reset input clears every enable bit except a chosen pair that relates to bus reset; those two keep their values. The register bus decoding and the event sources sit outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse-type source's event input, when high at a clock edge, sets its flag, and the flag is visible on `irq_flags` right after that edge.
- R2: A level-type source (bit i set in `EDGE_SRC`, by default bits 6 and 7) sets its flag once, on the first edge where its input is seen high after being low. Holding the input high does not set the flag again after the processor has cleared it.
- R3: With `clr_wr` high, each 1 in `clr_data` clears the matching flag at that edge. Bits written as 0, and cycles with `clr_wr` low, leave the flags unchanged.
- R4: If a set and a clear reach the same flag at the same edge, the flag ends up set.
- R5: `en_wr` loads `en_data` into `irq_en`. `bus_rst` takes priority and clears every enable bit except those in `KEEP_MASK` (by default bits 0 and 1), which hold their value.
- R6: With `ie` low, `int_oe` is 0 and the pin is released.
- R7: With `level_mode` high and `ie` high, `int_oe` is 1 and `int_out` is 0 while at least one flag is pending with its enable set. `int_oe` returns to 0 at the edge that removes the last such flag. `pos_pol` has no effect in this style.
- R8: With `level_mode` low and `ie` high, `int_oe` is 1. When the enabled-pending condition rises, a pulse of exactly `CLK_HZ/1e6*20` clocks follows. During the pulse `int_out` equals `pos_pol`; outside it, `int_out` is the inverse.
- R9: In pulse style, if an edge clears an enabled flag and an enabled flag is still pending after it, a new pulse starts, provided no pulse is running.
- R10: A pulse that is running is never lengthened or restarted. A start condition that occurs while a pulse runs is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | N_SRC | Event pulses, or status levels for the bits in EDGE_SRC |
| clr_wr | input | 1 | Write strobe for flag clearing |
| clr_data | input | N_SRC | Write-one-to-clear mask |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_data | input | N_SRC | New enable bits |
| bus_rst | input | 1 | Bus reset; clears the enables outside KEEP_MASK |
| ie | input | 1 | Global pin enable |
| level_mode | input | 1 | 1 selects level style, 0 selects pulse style |
| pos_pol | input | 1 | Pulse polarity, 1 for high-going pulses |
| irq_flags | output | N_SRC | Request flags |
| irq_en | output | N_SRC | Enable bits |
| int_oe | output | 1 | Pin drive enable; 0 means released |
| int_out | output | 1 | Level driven on the pin when int_oe is 1 |

## Verification
Flags and enables change at the edge that samples the stimulus, so they are checked on the falling edge of the next cycle. In level style the pin follows the flags with no added delay. A pulse start condition is seen one cycle after the flags change, and the pulse appears on the pin after the next edge; it lasts exactly the configured count. The bench drives every input just after a falling edge. A behavioural model steps at each rising edge, and the outputs are compared with the model at each falling edge, so every result is checked in the cycle it is due. Directed checks add pulse-width counts, the enable values after a bus reset, and the released pin.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef struct packed {
    logic ie;
    logic level_mode;
    logic pos_pol;
  } pin_cfg_t;

  function automatic int pulse_cycles(input int clk_hz, input int width_us);
    return (clk_hz / 1_000_000) * width_us;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          N_SRC    = 8,
  parameter logic [N_SRC-1:0] EDGE_SRC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             clr_wr,
  input  logic [N_SRC-1:0] clr_data,
  output logic [N_SRC-1:0] flags_q,
  output logic [N_SRC-1:0] flags_d
);

  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_data : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_SRC[i]) begin : g_edge
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= src_in[i];
      end
      assign set_vec[i] = src_in[i] & ~lvl_q;
    end else begin : g_pulse
      assign set_vec[i] = src_in[i];
    end

    always_comb begin
      if (set_vec[i])      flags_d[i] = 1'b1;
      else if (clr_eff[i]) flags_d[i] = 1'b0;
      else                 flags_d[i] = flags_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R3
  clear_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |=> ((($past(flags_q) & ~flags_q) & ~$past(clr_eff)) == '0));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int               N_SRC     = 8,
  parameter logic [N_SRC-1:0] KEEP_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_data,
  input  logic             bus_rst,
  output logic [N_SRC-1:0] en_q
);

  logic [N_SRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (bus_rst)    en_d = en_q & KEEP_MASK;
    else if (en_wr) en_d = en_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // R5
  bus_rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (((en_q & ~KEEP_MASK) == '0) &&
                 ((en_q & KEEP_MASK) == ($past(en_q) & KEEP_MASK))));

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_on
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign pulse_on = (cnt_q != '0);
  assign cnt_en   = pulse_on | fire;

  always_comb begin
    if (pulse_on) cnt_d = cnt_q - 1'b1;
    else          cnt_d = CW'(PULSE_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> $past(fire));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_on && fire) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int               N_SRC     = 8,
  parameter int               CLK_HZ    = 100_000_000,
  parameter int               PULSE_US  = 20,
  parameter logic [N_SRC-1:0] EDGE_SRC  = 8'hC0,
  parameter logic [N_SRC-1:0] KEEP_MASK = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             clr_wr,
  input  logic [N_SRC-1:0] clr_data,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_data,
  input  logic             bus_rst,
  input  logic             ie,
  input  logic             level_mode,
  input  logic             pos_pol,
  output logic [N_SRC-1:0] irq_flags,
  output logic [N_SRC-1:0] irq_en,
  output logic             int_oe,
  output logic             int_out
);

  localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_US);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [N_SRC-1:0] flags_q;
  logic [N_SRC-1:0] flags_d;
  logic             pend;
  logic             pend_q;
  logic             drop_q;
  logic             drop_d;
  logic             fire;
  logic             pulse_on;
  pin_cfg_t         cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cfg = '{ie: ie, level_mode: level_mode, pos_pol: pos_pol};

  irq_flag_bank #(.N_SRC(N_SRC), .EDGE_SRC(EDGE_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src_in   (src_in),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .flags_q  (flags_q),
    .flags_d  (flags_d)
  );

  irq_enable_reg #(.N_SRC(N_SRC), .KEEP_MASK(KEEP_MASK)) u_en (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_wr   (en_wr),
    .en_data (en_data),
    .bus_rst (bus_rst),
    .en_q    (irq_en)
  );

  assign pend   = |(flags_q & irq_en);
  assign drop_d = |(flags_q & ~flags_d & irq_en);
  assign fire   = cfg.ie & ~cfg.level_mode & pend & (~pend_q | drop_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      pend_q <= pend;
      drop_q <= drop_d;
    end
  end

  irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fire     (fire),
    .pulse_on (pulse_on)
  );

  always_comb begin
    if (cfg.level_mode) begin
      int_oe  = cfg.ie & pend;
      int_out = ~pend;
    end else begin
      int_oe  = cfg.ie;
      int_out = cfg.pos_pol ? pulse_on : ~pulse_on;
    end
  end

  assign irq_flags = flags_q;

  // R6
  released_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ie |-> !int_oe);

  // R7
  level_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (level_mode && int_oe) |-> (!int_out && (flags_q & irq_en) != '0));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  localparam int         N    = 8;
  localparam int         PCYC = 20;
  localparam logic [7:0] EDGE = 8'hC0;
  localparam logic [7:0] KEEP = 8'h03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic clr_wr = 1'b0;
  logic [N-1:0] clr_data = '0;
  logic en_wr = 1'b0;
  logic [N-1:0] en_data = '0;
  logic bus_rst = 1'b0;
  logic ie = 1'b0;
  logic level_mode = 1'b1;
  logic pos_pol = 1'b1;
  logic [N-1:0] irq_flags;
  logic [N-1:0] irq_en;
  logic int_oe;
  logic int_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  logic [7:0] m_flags = '0;
  logic [7:0] m_en = '0;
  logic [7:0] m_lvl = '0;
  bit m_pend_q = 1'b0;
  bit m_drop_q = 1'b0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  irq_aggregator #(.N_SRC(N), .CLK_HZ(1_000_000), .PULSE_US(20),
                   .EDGE_SRC(EDGE), .KEEP_MASK(KEEP)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .clr_wr(clr_wr),
    .clr_data(clr_data), .en_wr(en_wr), .en_data(en_data), .bus_rst(bus_rst),
    .ie(ie), .level_mode(level_mode), .pos_pol(pos_pol),
    .irq_flags(irq_flags), .irq_en(irq_en), .int_oe(int_oe), .int_out(int_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    if (model_on) begin
      logic [7:0] nxt;
      bit pend, fire, dropped, s;
      pend = (m_flags & m_en) != 0;
      fire = ie && !level_mode && pend && (!m_pend_q || m_drop_q) && m_cnt == 0;
      dropped = 1'b0;
      for (int i = 0; i < N; i++) begin
        s = EDGE[i] ? (src_in[i] && !m_lvl[i]) : src_in[i];
        if (s) nxt[i] = 1'b1;
        else if (clr_wr && clr_data[i]) nxt[i] = 1'b0;
        else nxt[i] = m_flags[i];
        if (m_flags[i] && !nxt[i] && m_en[i]) dropped = 1'b1;
      end
      if (bus_rst) m_en = m_en & KEEP;
      else if (en_wr) m_en = en_data;
      m_lvl = src_in;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      else if (fire) m_cnt = PCYC;
      m_pend_q = pend;
      m_drop_q = dropped;
      m_flags = nxt;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (model_on) begin
      bit pend, eoe, eout, pul;
      pend = (m_flags & m_en) != 0;
      pul = m_cnt != 0;
      eoe = ie && (level_mode ? pend : 1'b1);
      eout = level_mode ? !pend : (pos_pol ? pul : !pul);
      chk("R1/R2/R3/R4 flags", irq_flags, m_flags);
      chk("R5 enables", irq_en, m_en);
      chk("R6/R7/R8 int_oe", int_oe, eoe);
      if (eoe) chk("R7/R8/R9/R10 int_out", int_out, eout);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic evt(input logic [7:0] m);
    src_in = (src_in & EDGE) | m;
    tick(1);
    src_in = src_in & EDGE;
  endtask

  task automatic w1c(input logic [7:0] m);
    clr_wr = 1'b1; clr_data = m;
    tick(1);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic wen(input logic [7:0] m);
    en_wr = 1'b1; en_data = m;
    tick(1);
    en_wr = 1'b0;
  endtask

  // count high cycles on int_out over a window
  task automatic count_high(input int win, output int hi);
    hi = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (int_out) hi++;
    end
    #1;
  endtask

  initial begin
    int hi;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    model_on = 1'b1;
    chk("reset flags", irq_flags, 0);
    chk("reset enables", irq_en, 0);
    chk("R6 reset pin released", int_oe, 0);

    // R1 events and R7 level style
    ie = 1'b1; level_mode = 1'b1; pos_pol = 1'b1;
    wen(8'h0F);
    evt(8'h05);
    tick(1);
    chk("R1 flags set", irq_flags, 8'h05);
    chk("R7 pin low active", {int_oe, int_out}, 2'b10);
    pos_pol = 1'b0; tick(1);
    chk("R7 polarity ignored", {int_oe, int_out}, 2'b10);
    // R3 write of zeros does nothing
    w1c(8'h00); tick(1);
    chk("R3 zero write", irq_flags, 8'h05);
    w1c(8'h01); tick(1);
    chk("R3 clear one", irq_flags, 8'h04);
    chk("R7 still pending", int_oe, 1);
    w1c(8'h04); tick(1);
    chk("R7 released after last", int_oe, 0);
    // disabled flag does not drive pin
    evt(8'h20); tick(1);
    chk("R7 masked flag", int_oe, 0);
    w1c(8'h20);

    // R2 level-type source
    src_in[6] = 1'b1; tick(3);
    chk("R2 rising sets", irq_flags[6], 1);
    w1c(8'h40); tick(3);
    chk("R2 held level no reset", irq_flags[6], 0);
    src_in[6] = 1'b0; tick(2);
    src_in[6] = 1'b1; tick(2);
    chk("R2 second rising", irq_flags[6], 1);
    src_in[6] = 1'b0; w1c(8'h40);

    // R4 set beats clear
    evt(8'h02); tick(1);
    clr_wr = 1'b1; clr_data = 8'h02; src_in[1] = 1'b1;
    tick(1);
    clr_wr = 1'b0; clr_data = '0; src_in[1] = 1'b0;
    tick(1);
    chk("R4 set wins", irq_flags[1], 1);
    w1c(8'h02); tick(1);

    // R5 bus reset keeps two enables
    wen(8'hFF); tick(1);
    bus_rst = 1'b1; en_wr = 1'b1; en_data = 8'hAA;
    tick(1);
    bus_rst = 1'b0; en_wr = 1'b0;
    tick(1);
    chk("R5 bus reset keep", irq_en, 8'h03);
    wen(8'h0F); tick(1);

    // R6 released
    ie = 1'b0; evt(8'h01); tick(2);
    chk("R6 ie off", int_oe, 0);
    w1c(8'h01); tick(2);

    // R8 pulse style, positive
    ie = 1'b1; level_mode = 1'b0; pos_pol = 1'b1;
    tick(2);
    evt(8'h01);
    count_high(40, hi);
    chk("R8 pulse width", hi, PCYC);
    // R9 second pending, clear first after pulse finished
    evt(8'h02); tick(5);
    w1c(8'h01);
    count_high(40, hi);
    chk("R9 repulse on clear", hi, PCYC);
    w1c(8'h02); tick(2);

    // R10 clear during running pulse does not restart
    evt(8'h07);
    tick(3);
    w1c(8'h01);
    count_high(50, hi);
    chk("R10 no restart", hi, PCYC - 4);
    w1c(8'h06); tick(2);

    // R8 negative polarity
    pos_pol = 1'b0; tick(2);
    evt(8'h08);
    count_high(40, hi);
    chk("R8 negative pulse", 40 - hi, PCYC);
    w1c(8'h08); tick(3);

    model_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule